// File: doc/BRIEF.md
# Five-Tuple Flow Hash Unit

This block turns an IPv4 connection tuple (source address, destination address, source port, destination port) into a bucket index for a 4096-slot flow table. The index is always even, so each result selects a pair of neighbouring slots. The two directions of a connection are separate tuples. Each direction is hashed on its own, and each is placed in its own bucket pair.

The mixing works in four steps. First, the two ports are joined into one 32-bit word, with the source port in the upper half. Each bit of that word chooses between the destination address bit (port bit 1) and the source address bit (port bit 0). The chosen word is rotated left by eight places. It is then XOR-ed with the port word and with both addresses. The 32-bit result is folded by XOR-ing its upper half onto its low twenty bits. The low eleven bits of the fold are kept and doubled.

The unit is a two-stage pipeline with a valid/ready handshake on both sides. It accepts one tuple per cycle when the consumer is ready, and it holds its result steady while the consumer stalls.

Top module: `flow_hash_unit`

## Requirements
- R1: Let P = {srcPort, dstPort}, with srcPort in bits 31:16. The selected word is M = (P & dstAddr) | (~P & srcAddr). Each bit is taken from dstAddr where P is 1 and from srcAddr where P is 0.
- R2: M is rotated left by 8: bits 23:0 move to 31:8 and bits 31:24 move to 7:0.
- R3: The mixed word is H = P ^ dstAddr ^ srcAddr ^ rotated M.
- R4: The fold is F = (H >> 16) ^ (H & 0xFFFFF). Only F[10:0] is kept, and all higher bits are dropped.
- R5: outIndex = {F[10:0], 1'b0}. It is always even and always below 4096.
- R6: A tuple accepted at a clock edge (inValid and inReady both high) with outReady high appears on outValid/outIndex after the second following edge.
- R7: While outReady is high, inReady stays high, so the unit takes one tuple per cycle.
- R8: While outValid is high and outReady is low, outValid and outIndex hold their values. Every accepted tuple produces exactly one result, in acceptance order.
- R9: inReady is high whenever outValid is low.
- R10: After reset, outValid is low and inReady is high.
- R11: A reply tuple (addresses swapped and ports swapped) is hashed from its own fields. Its result is independent of any earlier tuple.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Tuple on the inputs is valid |
| inReady | output | 1 | Unit can accept a tuple this cycle |
| srcAddr | input | 32 | IPv4 source address |
| dstAddr | input | 32 | IPv4 destination address |
| srcPort | input | 16 | Source port |
| dstPort | input | 16 | Destination port |
| outValid | output | 1 | outIndex holds a result |
| outReady | input | 1 | Consumer takes the result this cycle |
| outIndex | output | 12 | Even bucket index into the 4096-slot table |

## Verification
The embedded properties check the handshake rules on every cycle:
- A stalled result stays frozen (R8).
- outValid drops only after the consumer has taken the result (R8).
- inReady is high whenever the output is empty or the consumer is ready (R7, R9).
- A result appears only after stage one was full (R6).

The value of the hash itself can only be shown by the bench scenarios. Hand-worked vectors isolate each part of the mix: the select by the ports, the rotation, the XOR, the fold truncation and the largest index. Random tuples are then compared in order against a model, under steady flow and under random backpressure. The two-cycle latency and the reply-direction hashing are also shown by bench scenarios only.

// File: rtl/fhash_pkg.sv
package fhash_pkg;
  // Strobes from the handshake control to the datapath stages
  typedef struct packed {
    logic loadMix;   // capture the mixed word into stage 1
    logic loadFold;  // capture the folded index into stage 2
  } stage_strobe_t;
endpackage

// File: rtl/fhash_ctrl.sv
module fhash_ctrl
  import fhash_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output logic          inReady,
  input  logic          outReady,
  output logic          outValid,
  output stage_strobe_t strobe
);
  logic stage1Full;
  logic stage2Full;
  logic advance1;
  logic advance2;

  // A stage may move when the stage after it is free or is draining this cycle
  always_comb begin
    advance2        = !stage2Full || outReady;
    advance1        = !stage1Full || advance2;
    strobe.loadMix  = advance1 && inValid;
    strobe.loadFold = advance2 && stage1Full;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Full <= 1'b0;
      stage2Full <= 1'b0;
    end else begin
      if (advance1) stage1Full <= inValid;
      if (advance2) stage2Full <= stage1Full;
    end
  end

  assign inReady  = advance1;
  assign outValid = stage2Full;

  // R6: a result can only appear one cycle after stage 1 held a tuple
  a_r6_fill_order: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(stage1Full));
endmodule

// File: rtl/fhash_datapath.sv
module fhash_datapath
  import fhash_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PORT_W     = 16,
  parameter int ROT_AMT    = 8,
  parameter int FOLD_SHIFT = 16,
  parameter int FOLD_KEEP  = 20,
  parameter int IDX_W      = 11,
  localparam int OUT_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  stage_strobe_t     strobe,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [PORT_W-1:0] srcPort,
  input  logic [PORT_W-1:0] dstPort,
  output logic [OUT_W-1:0]  outIndex
);
  localparam logic [ADDR_W-1:0] KEEP_MASK = ADDR_W'((64'(1) << FOLD_KEEP) - 64'(1));

  logic [ADDR_W-1:0] portWord;
  logic [ADDR_W-1:0] selWord;
  logic [ADDR_W-1:0] rotWord;
  logic [ADDR_W-1:0] mixNext;
  logic [ADDR_W-1:0] mixReg;
  logic [IDX_W-1:0]  foldLow;
  logic [OUT_W-1:0]  idxReg;

  // Stage 1: port-driven select, rotate, four-way xor
  always_comb begin
    portWord = {srcPort, dstPort};
    selWord  = (portWord & dstAddr) | (~portWord & srcAddr);
    rotWord  = {selWord[ADDR_W-ROT_AMT-1:0], selWord[ADDR_W-1:ADDR_W-ROT_AMT]};
    mixNext  = portWord ^ dstAddr ^ srcAddr ^ rotWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               mixReg <= '0;
    else if (strobe.loadMix) mixReg <= mixNext;
  end

  // Stage 2: fold the upper half onto the low field, keep IDX_W bits, double
  always_comb begin
    foldLow = IDX_W'(mixReg >> FOLD_SHIFT) ^ IDX_W'(mixReg & KEEP_MASK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                idxReg <= '0;
    else if (strobe.loadFold) idxReg <= {foldLow, 1'b0};
  end

  assign outIndex = idxReg;

  // R5: the index register only changes when stage 2 loads
  a_r5_idx_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadFold |=> $stable(outIndex));
endmodule

// File: rtl/flow_hash_unit.sv
module flow_hash_unit
  import fhash_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PORT_W     = 16,
  parameter int IDX_W      = 11,
  localparam int OUT_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [PORT_W-1:0] srcPort,
  input  logic [PORT_W-1:0] dstPort,
  output logic              outValid,
  input  logic              outReady,
  output logic [OUT_W-1:0]  outIndex
);
  stage_strobe_t strobe;

  fhash_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outReady (outReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  fhash_datapath #(
    .ADDR_W     (ADDR_W),
    .PORT_W     (PORT_W),
    .ROT_AMT    (8),
    .FOLD_SHIFT (16),
    .FOLD_KEEP  (20),
    .IDX_W      (IDX_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .srcAddr  (srcAddr),
    .dstAddr  (dstAddr),
    .srcPort  (srcPort),
    .dstPort  (dstPort),
    .outIndex (outIndex)
  );

  // R8: a stalled result is frozen
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outIndex));

  // R8: a result is only withdrawn after it was taken
  a_r8_no_drop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> $past(outReady));

  // R9: an empty output never blocks the input
  a_r9_ready_empty: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

  // R7: a ready consumer keeps the input open every cycle
  a_r7_full_rate: assert property (@(posedge clk) disable iff (!rstN)
    outReady |-> inReady);
endmodule

// File: tb/sim_flow_hash_unit.sv
module sim_flow_hash_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] srcAddr = '0;
  logic [31:0] dstAddr = '0;
  logic [15:0] srcPort = '0;
  logic [15:0] dstPort = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [11:0] outIndex;

  int testsRun = 0;
  int testsFailed = 0;
  int popCount = 0;
  logic [11:0] expQ[$];
  bit          prevHold = 1'b0;
  logic [11:0] prevIdx = '0;

  always #2 clk = ~clk;

  flow_hash_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .srcPort(srcPort), .dstPort(dstPort),
    .outValid(outValid), .outReady(outReady), .outIndex(outIndex)
  );

  function automatic logic [11:0] refHash(logic [31:0] sa, logic [31:0] da,
                                          logic [15:0] sp, logic [15:0] dp);
    logic [31:0] p, m, r, h, f;
    p = {sp, dp};
    m = (p & da) | (~p & sa);
    r = (m << 8) | (m >> 24);
    h = p ^ da ^ sa ^ r;
    f = (h >> 16) ^ (h & 32'h000F_FFFF);
    return {f[10:0], 1'b0};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard: model on acceptance, in-order compare on delivery, stall hold
  always @(negedge clk) begin
    if (rstN) begin
      if (inValid && inReady) expQ.push_back(refHash(srcAddr, dstAddr, srcPort, dstPort));
      if (prevHold)
        chk(outValid && outIndex == prevIdx, "R8 stalled output held", {20'b0, outIndex}, {20'b0, prevIdx});
      if (outValid && outReady) begin
        if (expQ.size() == 0) chk(1'b0, "R8 result without input", {20'b0, outIndex}, 32'h0);
        else begin
          logic [11:0] e;
          e = expQ.pop_front();
          chk(outIndex == e, "R4 hash matches model", {20'b0, outIndex}, {20'b0, e});
          chk(outIndex[0] == 1'b0, "R5 index even", {31'b0, outIndex[0]}, 32'h0);
        end
        popCount++;
      end
      prevHold = outValid && !outReady;
      prevIdx  = outIndex;
    end
  end

  task automatic run_one(logic [31:0] sa, logic [31:0] da, logic [15:0] sp,
                         logic [15:0] dp, logic [11:0] exp, string req);
    bit seen = 1'b0;
    @(posedge clk); #1;
    srcAddr = sa; dstAddr = da; srcPort = sp; dstPort = dp; inValid = 1'b1;
    forever begin @(negedge clk); if (inReady) break; end
    @(posedge clk); #1;
    inValid = 1'b0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      if (outValid) begin
        seen = 1'b1;
        chk(outIndex == exp, req, {20'b0, outIndex}, {20'b0, exp});
      end
    end
    if (!seen) chk(1'b0, {req, " no output"}, 32'h0, {20'b0, exp});
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(outValid == 1'b0, "R10 outValid low in reset", {31'b0, outValid}, 32'h0);
    chk(inReady == 1'b1, "R10 inReady high in reset", {31'b0, inReady}, 32'h1);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R10 outValid low after reset", {31'b0, outValid}, 32'h0);
    chk(inReady == 1'b1, "R9 inReady with empty output", {31'b0, inReady}, 32'h1);
  endtask

  task automatic test_known();
    outReady = 1'b1;
    run_one(32'h0, 32'h0, 16'h0, 16'h0, 12'h000, "R1 all-zero tuple");
    run_one(32'h0, 32'h0, 16'hFFFF, 16'hFFFF, 12'h000, "R1 ports all ones select dst");
    run_one(32'h0, 32'h0000_0001, 16'h0, 16'h0, 12'h002, "R3 dst bit0 xor");
    run_one(32'h0000_0001, 32'h0, 16'h0, 16'h0, 12'h202, "R2 src bit0 selected and rotated by 8");
    run_one(32'h0, 32'h0, 16'h0, 16'h0001, 12'h002, "R1 port word low bit is dstPort");
    run_one(32'h0, 32'h0001_0000, 16'h0, 16'h0, 12'h002, "R4 fold of bit16 onto bit0");
    run_one(32'h0, 32'h0000_0800, 16'h0, 16'h0, 12'h000, "R4 bit11 dropped");
    run_one(32'h0, 32'h0000_07FF, 16'h0, 16'h0, 12'hFFE, "R5 largest index");
  endtask

  task automatic test_latency();
    outReady = 1'b1;
    @(posedge clk); #1;
    srcAddr = 32'hC0A8_0001; dstAddr = 32'h0A00_0002; srcPort = 16'd1234; dstPort = 16'd80;
    inValid = 1'b1;
    @(negedge clk);
    @(posedge clk); #1;
    inValid = 1'b0;
    @(negedge clk);
    chk(outValid == 1'b0, "R6 not valid after one edge", {31'b0, outValid}, 32'h0);
    @(negedge clk);
    chk(outValid == 1'b1, "R6 valid after two edges", {31'b0, outValid}, 32'h1);
    chk(outIndex == refHash(32'hC0A8_0001, 32'h0A00_0002, 16'd1234, 16'd80),
        "R6 latency result", {20'b0, outIndex},
        {20'b0, refHash(32'hC0A8_0001, 32'h0A00_0002, 16'd1234, 16'd80)});
  endtask

  task automatic test_stream();
    int stalls = 0;
    int startPop;
    repeat (3) @(posedge clk);
    startPop = popCount;
    outReady = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      srcAddr = $urandom; dstAddr = $urandom; srcPort = 16'($urandom); dstPort = 16'($urandom);
      inValid = 1'b1;
      @(negedge clk);
      if (!inReady) stalls++;
    end
    @(posedge clk); #1;
    inValid = 1'b0;
    repeat (4) @(negedge clk);
    chk(stalls == 0, "R7 no input stall at full rate", stalls, 0);
    chk(popCount - startPop == 200, "R7 all streamed results delivered", popCount - startPop, 200);
  endtask

  task automatic test_backpressure();
    int startPop;
    bit done = 1'b0;
    startPop = popCount;
    fork
      begin
        for (int i = 0; i < 300; i++) begin
          @(posedge clk); #1;
          srcAddr = $urandom; dstAddr = $urandom; srcPort = 16'($urandom); dstPort = 16'($urandom);
          inValid = 1'b1;
          forever begin @(negedge clk); if (inReady) break; @(posedge clk); #1; end
        end
        @(posedge clk); #1;
        inValid = 1'b0;
        done = 1'b1;
      end
      begin
        while (!done) begin
          @(posedge clk); #1;
          outReady = ($urandom % 3) != 0;
        end
        outReady = 1'b1;
      end
    join
    repeat (6) @(negedge clk);
    chk(popCount - startPop == 300, "R8 every tuple produced one result", popCount - startPop, 300);
    chk(expQ.size() == 0, "R8 nothing left pending", expQ.size(), 0);
  endtask

  task automatic test_reply();
    logic [31:0] a = 32'hC0A8_010A;
    logic [31:0] b = 32'h5DB8_D822;
    outReady = 1'b1;
    run_one(a, b, 16'd40000, 16'd443, refHash(a, b, 16'd40000, 16'd443), "R11 original direction");
    run_one(b, a, 16'd443, 16'd40000, refHash(b, a, 16'd443, 16'd40000), "R11 reply direction");
    run_one(32'hCB00_7105, b, 16'd1024, 16'd443, refHash(32'hCB00_7105, b, 16'd1024, 16'd443),
            "R11 translated original");
  endtask

  initial begin
    #(200000 * 4);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(posedge clk);
    test_reset();
    test_known();
    test_latency();
    test_stream();
    test_backpressure();
    test_reply();
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule